// File: doc/BRIEF.md
# Single-Wire Command Slave Interface

This block is the device end of a bidirectional one-wire serial link. The line has an open-drain pad with a pull-up. Every bit slot is opened by the host, which pulls the line low. After that low phase, one of two things happens. If the device is receiving, the host presents the bit level and the block samples it. If the device is replying, the block enables its pull-down for a '0' or leaves the line released for a '1'. All timing is counted in cycles of the system clock. The line input passes through a two-flop synchronizer before any edge is detected.

Slots are grouped into telegrams:

- a '0' start bit;
- a four-bit command code;
- a four-bit data nibble, written by the host or returned by the device;
- an acknowledge slot, in which the device drives '0'.

Each completed telegram is handed to the rest of the chip as a one-cycle strobe with its code and nibble. Timing violations and telegrams that break off partway raise a framing-error strobe, and the receiver then returns to waiting for a start bit.

The block also decides when the device goes to standby. There are two paths:

- **Idle timeout.** The line stays high for a long timeout. The clock-enable output stays high on this path, so an attached host keeps its clock.
- **Standby command.** Code 0 is written with data bit 3 set. Standby then starts as soon as that bit is sampled, no acknowledge is driven, and the clock-enable output falls.

Standby lasts until the wake input is pulsed.

Top module: `swc_cmd_slave`

## Requirements
- R1: A falling edge of the synchronized line opens a bit slot. Inside a telegram (after its start bit), a low phase shorter than SYNC_CYC cycles is a framing error.
- R2: In a receive slot, the line level is sampled SYNC_CYC+SETUP_CYC cycles after the slot's falling edge is detected.
- R3: In a transmit slot carrying '0', the device enables pull_o from SYNC_CYC up to SYNC_CYC+SETUP_CYC+DATA_CYC cycles after the detected falling edge, without a break. For a '1', pull_o stays low.
- R4: A telegram is built as follows:
  - a start slot sampled '0';
  - four command slots, code bit 0 first;
  - four data slots, data bit 0 first;
  - one acknowledge slot.

  While waiting for a start bit, a slot sampled '1' (such as a stop bit) is ignored.
- R5: A command code with bit 3 set is a status read. The device returns status_i, captured when the fourth command bit is sampled, bit 0 first. cmd_data_o then carries the value that was sent.
- R6: After the last data bit of a non-standby telegram, cmd_valid_o pulses for exactly one cycle, with cmd_code_o and cmd_data_o valid. The device then drives '0' in the acknowledge slot.
- R7: Inside a telegram, if the line was high for fewer than REC_CYC cycles before a slot's falling edge, frame_err_o pulses and the receiver returns to waiting for a start bit.
- R8: Inside a telegram, if the line stays high for FRAME_TO_CYC cycles, frame_err_o pulses and the receiver returns to waiting for a start bit.
- R9: Outside standby, IDLE_TO_CYC consecutive high cycles on the line set standby_o, with clk_en_o staying high. Any low level restarts that count.
- R10: When code 0 is written with data bit 3 set, the following happens:
  - standby_o rises right after that bit is sampled;
  - clk_en_o falls;
  - there is no acknowledge drive and no cmd_valid_o pulse.

  Any other code with data bit 3 set is an ordinary command.
- R11: standby_o stays set until wake_i is high at a clock edge, which clears it. During standby, line activity is ignored: pull_o stays low and no strobes appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_i | input | 1 | Level of the single-wire line from the pad |
| wake_i | input | 1 | Clears standby |
| status_i | input | 4 | Nibble returned to the host on a status read |
| pull_o | output | 1 | Enables the pad pull-down |
| cmd_valid_o | output | 1 | One-cycle strobe for a completed telegram |
| cmd_code_o | output | 4 | Command code of the last telegram |
| cmd_data_o | output | 4 | Data nibble of the last telegram |
| frame_err_o | output | 1 | One-cycle framing-error strobe |
| standby_o | output | 1 | Standby level |
| clk_en_o | output | 1 | Low only in standby entered by command |

## Verification
The assertions assume that wake_i is never raised while the host is inside a telegram. They also assume that the host always keeps its low phase past the point where the device's pull-down takes over, so a device-driven '0' never shows a spurious rising and falling edge. The bench host meets both assumptions as follows:

- In reply slots it holds the sync phase for SYNC_CYC plus four cycles, which covers the synchronizer delay.
- In receive slots it holds the data level until the end of the data window.
- It pulses wake_i only while the line is idle.

Framing errors are produced only on purpose, with shortened low or high phases or an abandoned telegram.

// File: rtl/swc_pkg.sv
// Shared types for the single-wire command slave.
// Assumes a four-bit command nibble and a four-bit data nibble per telegram.
package swc_pkg;
    localparam int NIB_W = 4;
    localparam int IDX_W = $clog2(NIB_W);

    typedef logic [NIB_W-1:0] nib_t;

    typedef enum logic [1:0] {
        ST_WAIT,
        ST_CMD,
        ST_DATA,
        ST_ACK
    } frm_state_e;
endpackage

// File: rtl/swc_sync.sv
// Line synchronizer and edge detector.
// Brings the asynchronous line level into the clock domain through STAGES flops.
// One more flop holds the previous level for edge detection.
// Assumes the idle line is high, so the flops reset to one.
module swc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic fall_o,
    output logic rise_o
);
    logic [STAGES:0] pipe;

    // shift the raw line through the synchronizer and the history flop
    always_ff @(posedge clk) begin : sync_chain
        if (!rst_n) begin
            pipe <= '1;
        end else begin
            pipe <= {pipe[STAGES-1:0], line_i};
        end
    end

    assign level_o = pipe[STAGES-1];
    assign fall_o  = pipe[STAGES] & ~pipe[STAGES-1];
    assign rise_o  = ~pipe[STAGES] & pipe[STAGES-1];
endmodule

// File: rtl/swc_slot.sv
// Bit slot engine.
// Times each slot from the detected falling edge and samples the received bit.
// Enables the pull-down for a transmitted '0', and flags low phases that are
// too short and recovery highs that are too short.
// Assumes tx_en_i/tx_bit_i describe the slot that the next falling edge opens.
module swc_slot #(
    parameter int SYNC_CYC  = 40,
    parameter int SETUP_CYC = 40,
    parameter int DATA_CYC  = 80,
    parameter int REC_CYC   = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    input  logic level_i,
    input  logic fall_i,
    input  logic rise_i,
    input  logic tx_en_i,
    input  logic tx_bit_i,
    output logic bit_stb_o,
    output logic bit_val_o,
    output logic sync_short_o,
    output logic rec_short_o,
    output logic pull_o
);
    localparam int SAMPLE = SYNC_CYC + SETUP_CYC;
    localparam int WEND   = SAMPLE + DATA_CYC;
    localparam int CW     = $clog2(WEND + 1);
    localparam int RW     = $clog2(REC_CYC + 1);
    localparam logic [CW-1:0] C_SYNC = CW'(SYNC_CYC);
    localparam logic [CW-1:0] C_SAMP = CW'(SAMPLE);
    localparam logic [CW-1:0] C_WEND = CW'(WEND);
    localparam logic [RW-1:0] C_REC  = RW'(REC_CYC);

    logic          active;
    logic          drv_q;
    logic [CW-1:0] cnt;
    logic [RW-1:0] hi_cnt;
    logic          early_rise;

    assign early_rise   = active & rise_i & (cnt < C_SYNC);
    assign sync_short_o = early_rise & ~hold_i;
    assign rec_short_o  = fall_i & (hi_cnt < C_REC) & ~hold_i;
    assign bit_stb_o    = active & (cnt == C_SAMP) & ~hold_i;
    assign bit_val_o    = level_i;
    assign pull_o       = active & drv_q & (cnt >= C_SYNC) & (cnt < C_WEND) & ~hold_i;

    // count consecutive high cycles, saturating at the recovery minimum
    always_ff @(posedge clk) begin : recovery_count
        if (!rst_n || hold_i) begin
            hi_cnt <= C_REC;
        end else if (!level_i) begin
            hi_cnt <= '0;
        end else if (hi_cnt != C_REC) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    // open a slot on each falling edge, latch its drive, and run its timer
    always_ff @(posedge clk) begin : slot_timer
        if (!rst_n || hold_i) begin
            active <= 1'b0;
            drv_q  <= 1'b0;
            cnt    <= '0;
        end else if (fall_i) begin
            active <= 1'b1;
            drv_q  <= tx_en_i & ~tx_bit_i;
            cnt    <= CW'(1);
        end else if (active) begin
            if (early_rise || cnt == C_WEND) begin
                active <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/swc_frame.sv
// Telegram sequencer.
// Assembles start, command and data slots, supplies reply bits, and decodes
// the standby command. Issues command and framing-error strobes.
// Assumes one bit strobe per slot from the slot engine.
module swc_frame
    import swc_pkg::*;
#(
    parameter int FRAME_TO_CYC = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    input  logic level_i,
    input  logic bit_stb_i,
    input  logic bit_val_i,
    input  logic sync_short_i,
    input  logic rec_short_i,
    input  nib_t status_i,
    output logic tx_en_o,
    output logic tx_bit_o,
    output logic cmd_valid_o,
    output nib_t cmd_code_o,
    output nib_t cmd_data_o,
    output logic frame_err_o,
    output logic stby_req_o
);
    localparam int TW = $clog2(FRAME_TO_CYC + 1);
    localparam logic [TW-1:0] C_TO = TW'(FRAME_TO_CYC);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NIB_W - 1);

    frm_state_e       st;
    logic [IDX_W-1:0] idx;
    nib_t             cmd_q, dat_q, stat_q;
    logic             is_rd;
    logic [TW-1:0]    run_cnt;
    logic             frm_err;
    logic             dbit;

    assign frm_err  = (st != ST_WAIT) & (sync_short_i | rec_short_i | (run_cnt == C_TO));
    assign tx_en_o  = ((st == ST_DATA) & is_rd) | (st == ST_ACK);
    assign tx_bit_o = (st == ST_ACK) ? 1'b0 : stat_q[idx];
    assign dbit     = is_rd ? stat_q[idx] : bit_val_i;
    assign cmd_code_o = cmd_q;
    assign cmd_data_o = dat_q;

    // measure how long the line has been high inside a telegram
    always_ff @(posedge clk) begin : abort_timer
        if (!rst_n || hold_i || st == ST_WAIT || !level_i) begin
            run_cnt <= '0;
        end else if (run_cnt != C_TO) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // step through the telegram on each sampled bit
    always_ff @(posedge clk) begin : frame_seq
        if (!rst_n || hold_i) begin
            st          <= ST_WAIT;
            idx         <= '0;
            cmd_q       <= '0;
            dat_q       <= '0;
            stat_q      <= '0;
            is_rd       <= 1'b0;
            cmd_valid_o <= 1'b0;
            frame_err_o <= 1'b0;
            stby_req_o  <= 1'b0;
        end else begin
            cmd_valid_o <= 1'b0;
            frame_err_o <= 1'b0;
            stby_req_o  <= 1'b0;
            if (frm_err) begin
                st          <= ST_WAIT;
                frame_err_o <= 1'b1;
            end else if (bit_stb_i) begin
                unique case (st)
                    ST_WAIT: begin
                        if (!bit_val_i) begin
                            st  <= ST_CMD;
                            idx <= '0;
                        end
                    end
                    ST_CMD: begin
                        cmd_q[idx] <= bit_val_i;
                        if (idx == LAST) begin
                            st     <= ST_DATA;
                            idx    <= '0;
                            is_rd  <= bit_val_i;
                            stat_q <= status_i;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        dat_q[idx] <= dbit;
                        if (idx == LAST) begin
                            if (!is_rd && cmd_q == '0 && bit_val_i) begin
                                stby_req_o <= 1'b1;
                                st         <= ST_WAIT;
                            end else begin
                                cmd_valid_o <= 1'b1;
                                st          <= ST_ACK;
                            end
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                    ST_ACK: begin
                        st <= ST_WAIT;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/swc_power.sv
// Standby controller.
// Enters standby after a long high idle or on a command request, and
// remembers which path was taken. Leaves standby on the wake input.
// Assumes stby_req_i is a one-cycle strobe.
module swc_power #(
    parameter int IDLE_TO_CYC = 6_400_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic stby_req_i,
    input  logic wake_i,
    output logic standby_o,
    output logic clk_en_o
);
    localparam int IW = $clog2(IDLE_TO_CYC + 1);
    localparam logic [IW-1:0] C_LAST = IW'(IDLE_TO_CYC - 1);

    logic [IW-1:0] idle_cnt;
    logic          by_cmd;

    assign clk_en_o = ~(standby_o & by_cmd);

    // track idle time and the standby level with its source
    always_ff @(posedge clk) begin : standby_ctl
        if (!rst_n || wake_i) begin
            standby_o <= 1'b0;
            by_cmd    <= 1'b0;
            idle_cnt  <= '0;
        end else if (standby_o) begin
            idle_cnt <= '0;
        end else if (stby_req_i) begin
            standby_o <= 1'b1;
            by_cmd    <= 1'b1;
            idle_cnt  <= '0;
        end else if (!level_i) begin
            idle_cnt <= '0;
        end else if (idle_cnt == C_LAST) begin
            standby_o <= 1'b1;
            by_cmd    <= 1'b0;
            idle_cnt  <= '0;
        end else begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/swc_cmd_slave.sv
// Single-wire command slave, top level.
// Chains the synchronizer, the slot engine, the telegram sequencer and the
// standby controller. Assumes an open-drain pad: pull_o enables the pull-down,
// and line_i reads back the wired level.
module swc_cmd_slave
    import swc_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int SYNC_CYC     = 40,
    parameter int SETUP_CYC    = 40,
    parameter int DATA_CYC     = 80,
    parameter int REC_CYC      = 40,
    parameter int FRAME_TO_CYC = 2000,
    parameter int IDLE_TO_CYC  = 6_400_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_i,
    input  logic       wake_i,
    input  logic [3:0] status_i,
    output logic       pull_o,
    output logic       cmd_valid_o,
    output logic [3:0] cmd_code_o,
    output logic [3:0] cmd_data_o,
    output logic       frame_err_o,
    output logic       standby_o,
    output logic       clk_en_o
);
    logic level, fall, rise;
    logic bit_stb, bit_val, sync_short, rec_short;
    logic tx_en, tx_bit, stby_req;

    swc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .line_i(line_i),
        .level_o(level), .fall_o(fall), .rise_o(rise)
    );

    swc_slot #(
        .SYNC_CYC(SYNC_CYC), .SETUP_CYC(SETUP_CYC),
        .DATA_CYC(DATA_CYC), .REC_CYC(REC_CYC)
    ) u_slot (
        .clk(clk), .rst_n(rst_n), .hold_i(standby_o),
        .level_i(level), .fall_i(fall), .rise_i(rise),
        .tx_en_i(tx_en), .tx_bit_i(tx_bit),
        .bit_stb_o(bit_stb), .bit_val_o(bit_val),
        .sync_short_o(sync_short), .rec_short_o(rec_short),
        .pull_o(pull_o)
    );

    swc_frame #(.FRAME_TO_CYC(FRAME_TO_CYC)) u_frame (
        .clk(clk), .rst_n(rst_n), .hold_i(standby_o), .level_i(level),
        .bit_stb_i(bit_stb), .bit_val_i(bit_val),
        .sync_short_i(sync_short), .rec_short_i(rec_short),
        .status_i(status_i), .tx_en_o(tx_en), .tx_bit_o(tx_bit),
        .cmd_valid_o(cmd_valid_o), .cmd_code_o(cmd_code_o),
        .cmd_data_o(cmd_data_o), .frame_err_o(frame_err_o),
        .stby_req_o(stby_req)
    );

    swc_power #(.IDLE_TO_CYC(IDLE_TO_CYC)) u_power (
        .clk(clk), .rst_n(rst_n), .level_i(level),
        .stby_req_i(stby_req), .wake_i(wake_i),
        .standby_o(standby_o), .clk_en_o(clk_en_o)
    );
endmodule

// File: rtl/swc_chk.sv
// Port-level property checker for the single-wire command slave.
// It is attached to the top module by the bind at the end of this file.
module swc_chk (
    input logic clk,
    input logic rst_n,
    input logic wake_i,
    input logic pull_o,
    input logic cmd_valid_o,
    input logic frame_err_o,
    input logic standby_o,
    input logic clk_en_o
);
    AST_PULL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pull_o) |=> pull_o); // R3
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o); // R6
    AST_VALID_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid_o && frame_err_o)); // R7
    AST_CLK_STOP_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en_o |-> standby_o); // R10
    AST_STBY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (standby_o && !wake_i) |=> standby_o); // R11
    AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wake_i |=> !standby_o); // R11
    AST_NO_PULL_STBY: assert property (@(posedge clk) disable iff (!rst_n)
        standby_o |-> (!pull_o && !cmd_valid_o)); // R11
endmodule

bind swc_cmd_slave swc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wake_i(wake_i), .pull_o(pull_o),
    .cmd_valid_o(cmd_valid_o), .frame_err_o(frame_err_o),
    .standby_o(standby_o), .clk_en_o(clk_en_o)
);

// File: tb/swc_cmd_slave_test.sv
`timescale 1ns/100ps
module swc_cmd_slave_test;
    localparam int EV_CMD = 1;
    localparam int EV_ERR = 2;

    typedef struct {
        int         kind;
        logic [3:0] code;
        logic [3:0] data;
        string      tag;
    } ev_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_pull = 1'b0;
    logic       wake_i = 1'b0;
    logic [3:0] status_i = 4'h0;
    logic       line;
    logic       pull_o, cmd_valid_o, frame_err_o, standby_o, clk_en_o;
    logic [3:0] cmd_code_o, cmd_data_o;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;
    ev_t exp_q[$];

    always #2.5 clk = ~clk;

    assign line = ~(host_pull | pull_o);

    swc_cmd_slave #(
        .SYNC_CYC(4), .SETUP_CYC(6), .DATA_CYC(8), .REC_CYC(4),
        .FRAME_TO_CYC(100), .IDLE_TO_CYC(400)
    ) uut (
        .clk(clk), .rst_n(rst_n), .line_i(line), .wake_i(wake_i),
        .status_i(status_i), .pull_o(pull_o), .cmd_valid_o(cmd_valid_o),
        .cmd_code_o(cmd_code_o), .cmd_data_o(cmd_data_o),
        .frame_err_o(frame_err_o), .standby_o(standby_o), .clk_en_o(clk_en_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input int kind, input logic [3:0] code, input logic [3:0] data,
                        input string tag);
        ev_t e;
        e.kind = kind; e.code = code; e.data = data; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // host writes one bit: low sync, then the data level, then a high recovery
    task automatic slot_w(input logic b, input int hi = 10);
        host_pull = 1'b1; wait_n(6);
        host_pull = ~b;   wait_n(12);
        host_pull = 1'b0; wait_n(hi);
    endtask

    // host opens a reply slot and reads the line inside the data window
    task automatic slot_r(output logic b);
        host_pull = 1'b1; wait_n(8);
        host_pull = 1'b0; wait_n(6);
        b = line;
        wait_n(22);
    endtask

    // complete telegram with expected strobe, reply bits and acknowledge
    task automatic send_frame(input logic [3:0] code, input logic [3:0] data, input string tag);
        logic b;
        push(EV_CMD, code, code[3] ? status_i : data, tag);
        slot_w(1'b0);
        for (int i = 0; i < 4; i++) slot_w(code[i]);
        for (int i = 0; i < 4; i++) begin
            if (code[3]) begin
                slot_r(b);
                check(b == status_i[i], {tag, " reply bit"}, int'(b), int'(status_i[i]));
            end else begin
                slot_w(data[i]);
            end
        end
        slot_r(b);
        check(b == 1'b0, {tag, " ack low"}, int'(b), 0);
    endtask

    // monitor: compare each strobe with the head of the expected queue
    always @(negedge clk) begin
        if (rst_n && (cmd_valid_o || frame_err_o)) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "unexpected strobe", cmd_valid_o ? EV_CMD : EV_ERR, 0);
            end else begin
                ev_t e;
                e = exp_q.pop_front();
                if (e.kind == EV_CMD)
                    check(cmd_valid_o && cmd_code_o == e.code && cmd_data_o == e.data, e.tag,
                          {cmd_valid_o, cmd_code_o, cmd_data_o}, {1'b1, e.code, e.data});
                else
                    check(frame_err_o && !cmd_valid_o, e.tag,
                          {frame_err_o, cmd_valid_o}, 2);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic b;
        wait_n(10);
        rst_n = 1'b1;
        wait_n(4);
        check(!pull_o && !cmd_valid_o && !frame_err_o, "R11 reset outputs quiet",
              {pull_o, cmd_valid_o, frame_err_o}, 0);
        check(!standby_o && clk_en_o, "R9 reset not in standby", {standby_o, clk_en_o}, 1);

        send_frame(4'b0101, 4'b0011, "R2 R4 R6 write frame");
        wait_n(20);
        send_frame(4'b0000, 4'b0110, "R10 control 0 without standby");
        wait_n(20);
        slot_w(1'b1);
        wait_n(20);
        send_frame(4'b0010, 4'b1001, "R4 stop bit ignored");
        wait_n(20);

        status_i = 4'b0110;
        send_frame(4'b1010, 4'b0000, "R3 R5 status read");
        wait_n(20);
        status_i = 4'b1001;
        send_frame(4'b1111, 4'b0000, "R5 status read 2");
        status_i = 4'b0000;
        wait_n(20);

        // R1: short sync phase inside a telegram
        push(EV_ERR, 4'h0, 4'h0, "R1 short sync");
        slot_w(1'b0);
        host_pull = 1'b1; wait_n(2);
        host_pull = 1'b0; wait_n(30);
        send_frame(4'b0110, 4'b0101, "R1 recovers after error");
        wait_n(20);

        // R7: short recovery before the next slot
        push(EV_ERR, 4'h0, 4'h0, "R7 short recovery");
        slot_w(1'b0);
        slot_w(1'b0, 2);
        slot_w(1'b1);
        wait_n(20);
        send_frame(4'b0011, 4'b1110, "R7 recovers after error");
        wait_n(20);

        // R8: telegram abandoned partway
        push(EV_ERR, 4'h0, 4'h0, "R8 abort timeout");
        slot_w(1'b0);
        slot_w(1'b1);
        slot_w(1'b0);
        wait_n(150);
        check(!standby_o, "R8 abort not standby", standby_o, 0);
        slot_w(1'b1);

        // R9: low activity restarts the idle count; then a full idle
        wait_n(300);
        slot_w(1'b1);
        wait_n(300);
        check(!standby_o, "R9 idle restarted by low", standby_o, 0);
        wait_n(120);
        check(standby_o && clk_en_o, "R9 idle standby keeps clock", {standby_o, clk_en_o}, 3);

        // R11: line ignored in standby
        slot_w(1'b0);
        for (int i = 0; i < 8; i++) slot_w(1'b1);
        slot_r(b);
        check(b == 1'b1, "R11 no ack in standby", int'(b), 1);
        check(standby_o, "R11 standby holds", standby_o, 1);
        wake_i = 1'b1; wait_n(1); wake_i = 1'b0; wait_n(2);
        check(!standby_o && clk_en_o, "R11 wake clears", {standby_o, clk_en_o}, 1);
        send_frame(4'b0100, 4'b0111, "R11 frame after wake");
        wait_n(20);

        // R10: standby command
        slot_w(1'b0);
        for (int i = 0; i < 4; i++) slot_w(1'b0);
        slot_w(1'b0); slot_w(1'b0); slot_w(1'b0); slot_w(1'b1);
        check(standby_o && !clk_en_o, "R10 command standby stops clock",
              {standby_o, clk_en_o}, 2);
        slot_r(b);
        check(b == 1'b1, "R10 no ack after standby command", int'(b), 1);
        wake_i = 1'b1; wait_n(1); wake_i = 1'b0; wait_n(20);
        send_frame(4'b0100, 4'b1000, "R10 other code with bit 3");
        wait_n(40);

        check(exp_q.size() == 0, "R6 all expected strobes seen", exp_q.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule